// File: doc/BRIEF.md
# Bus Grant Watchdog Arbiter

This block shares one bus among a set of masters (sixteen by default). Each master raises a request line, and the arbiter hands out a one-hot grant when the bus is free. The grant goes to the requesting master with the lowest index among those that software has allowed to own the bus. The owner keeps the grant until it drops its request. After that the bus stays idle for one cycle, and then the next decision is made.

Every new grant starts a confirmation timer. The owning master is expected to raise the have-it acknowledge within a fixed number of cycles. If it does, the timer stops. If it does not, the block sets a per-master broken flag. These flags stay set until reset, and an interrupt line reports that at least one flag is set.

Software uses a small 64-bit register port with two addresses. The broken flags are read through it, and the per-master grant permissions are set and read through it. Permission for master 0, the bridge, is fixed on.

Top module: `bus_grant_watchdog`

## Requirements
- R1: When no grant is held, the next clock edge grants the lowest-indexed master whose request is high and whose permission bit is 1. `gnt` is registered and one-hot or zero.
- R2: A master whose permission bit is 0 is never granted, even while it requests.
- R3: A grant is held while the owner keeps its request high. The edge that sees the request low clears `gnt` to zero. A new grant is issued no earlier than the following edge.
- R4: Call the edge that sets the grant edge 0. If `have_it` is low at every edge from 1 to TIMEOUT, the owner's broken flag is set at edge TIMEOUT. If `have_it` is high at edge TIMEOUT, the flag stays clear.
- R5: Once `have_it` is seen, the timer for that grant stops. A later low `have_it` in the same grant never sets a flag.
- R6: Broken flags are sticky. Writes to the status address do not change them, and only reset returns them to 0. Their reset value is 0.
- R7: `irq` is the OR of all broken flags, registered one cycle after them. It stays high until reset.
- R8: `reg_addr`=0 selects the status word (flag of master i in bit i) and `reg_addr`=1 selects the permission word (bit i for master i). `reg_rdata` shows the selected word one edge after the address is presented. Bits 63:16 always read 0, and writes to them are ignored.
- R9: Permission bits 15:1 are writable when `reg_wr`=1 with `reg_addr`=1, and reset to 1. Bit 0 always reads 1, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Per-master bus request |
| have_it | input | 1 | Ownership acknowledge from the current owner |
| gnt | output | N_MASTERS | Registered one-hot grant |
| irq | output | 1 | Registered interrupt, OR of broken flags |
| reg_addr | input | 1 | 0 selects status, 1 selects permission |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Registered read data |

## Verification
The bench builds the block with the default of sixteen masters and a TIMEOUT of 12. The short timeout puts both sides of the expiry edge within a few cycles of each grant. At that width, random permission words and random request patterns reach every priority position, including a permitted master sitting above a barred one. Directed cases cover acknowledgement exactly on the last edge, an acknowledgement that later drops, a master barred while it requests, and a reset that clears sticky flags.

// File: rtl/bgw_pkg.sv
package bgw_pkg;
  localparam int unsigned STATUS_ADDR = 0;
  localparam int unsigned CTRL_ADDR   = 1;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bgw_arbiter.sv
module bgw_arbiter #(
  parameter int unsigned N_MASTERS = 16,
  localparam int unsigned IW = bgw_pkg::idx_w(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] en_i,
  output logic [N_MASTERS-1:0] gnt_o,
  output logic                 start_o,
  output logic [IW-1:0]        start_idx_o
);
  logic [N_MASTERS-1:0] gnt_q;
  logic [N_MASTERS-1:0] elig;
  logic [IW-1:0]        pick;
  logic                 any;

  assign elig = req_i & en_i;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick = IW'(i);
        any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
    end else if (gnt_q == '0) begin
      if (any) gnt_q <= N_MASTERS'(1) << pick;
    end else if ((gnt_q & req_i) == '0) begin
      gnt_q <= '0;
    end
  end

  assign start_o     = (gnt_q == '0) && any;
  assign start_idx_o = pick;
  assign gnt_o       = gnt_q;

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));

  // R2
  grant_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_q == '0) |=> ((gnt_q & ~$past(en_i)) == '0));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((gnt_q & req_i) != '0) |=> (gnt_q == $past(gnt_q)));
endmodule

// File: rtl/bgw_watchdog.sv
module bgw_watchdog #(
  parameter int unsigned N_MASTERS = 16,
  parameter int unsigned TIMEOUT   = 255,
  localparam int unsigned IW = bgw_pkg::idx_w(N_MASTERS),
  localparam int unsigned CW = $clog2(TIMEOUT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [IW-1:0]        start_idx_i,
  input  logic                 busy_i,
  input  logic                 have_it_i,
  output logic [N_MASTERS-1:0] broken_o,
  output logic                 irq_o
);
  logic [CW-1:0]        cnt_q;
  logic                 armed_q;
  logic [IW-1:0]        own_q;
  logic [N_MASTERS-1:0] broken_q;
  logic                 irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      own_q    <= '0;
      broken_q <= '0;
    end else if (start_i) begin
      cnt_q   <= CW'(TIMEOUT);
      armed_q <= 1'b1;
      own_q   <= start_idx_i;
    end else if (armed_q) begin
      if (!busy_i || have_it_i) begin
        armed_q <= 1'b0;
      end else if (cnt_q == CW'(1)) begin
        armed_q         <= 1'b0;
        broken_q[own_q] <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |broken_q;
  end

  assign broken_o = broken_q;
  assign irq_o    = irq_q;

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((broken_q & $past(broken_q)) == $past(broken_q)));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (broken_q != '0) |=> irq_q);

  // R5
  ack_stops_timer_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && have_it_i && !start_i) |=> (broken_q == $past(broken_q)));
endmodule

// File: rtl/bgw_regs.sv
module bgw_regs #(
  parameter int unsigned N_MASTERS = 16,
  parameter int unsigned REG_W     = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  input  logic [N_MASTERS-1:0] status_i,
  output logic [N_MASTERS-1:0] en_o,
  output logic [REG_W-1:0]     reg_rdata_o
);
  logic [N_MASTERS-1:1] en_q;
  logic [REG_W-1:0]     rdata_q;
  logic                 ctrl_sel;

  assign ctrl_sel = (reg_addr_i == 1'(bgw_pkg::CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (rst)                      en_q <= '1;
    else if (reg_wr_i && ctrl_sel) en_q <= reg_wdata_i[N_MASTERS-1:1];
  end

  assign en_o = {en_q, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (ctrl_sel) rdata_q <= REG_W'(en_o);
    else               rdata_q <= REG_W'(status_i);
  end

  assign reg_rdata_o = rdata_q;

  // R9
  bridge_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && ctrl_sel) |=> (en_o[0] && (en_o[N_MASTERS-1:1] == $past(reg_wdata_i[N_MASTERS-1:1]))));
endmodule

// File: rtl/bus_grant_watchdog.sv
module bus_grant_watchdog #(
  parameter int unsigned N_MASTERS = 16,
  parameter int unsigned TIMEOUT   = 255,
  parameter int unsigned REG_W     = 64,
  localparam int unsigned IW = bgw_pkg::idx_w(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 have_it,
  output logic [N_MASTERS-1:0] gnt,
  output logic                 irq,
  input  logic                 reg_addr,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata
);
  logic [N_MASTERS-1:0] en;
  logic [N_MASTERS-1:0] broken;
  logic                 start;
  logic [IW-1:0]        start_idx;

  bgw_arbiter #(.N_MASTERS(N_MASTERS)) u_arb (
    .clk(clk), .rst(rst), .req_i(req), .en_i(en),
    .gnt_o(gnt), .start_o(start), .start_idx_o(start_idx)
  );

  bgw_watchdog #(.N_MASTERS(N_MASTERS), .TIMEOUT(TIMEOUT)) u_wdog (
    .clk(clk), .rst(rst), .start_i(start), .start_idx_i(start_idx),
    .busy_i(gnt != '0), .have_it_i(have_it), .broken_o(broken), .irq_o(irq)
  );

  bgw_regs #(.N_MASTERS(N_MASTERS), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .status_i(broken), .en_o(en), .reg_rdata_o(reg_rdata)
  );

  // R8
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (reg_rdata[REG_W-1:N_MASTERS] == '0));
endmodule

// File: tb/bus_grant_watchdog_tb.sv
module bus_grant_watchdog_tb;
  localparam int N = 16;
  localparam int T = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic          have_it = 1'b0;
  logic [N-1:0]  gnt;
  logic          irq;
  logic          reg_addr = 1'b0;
  logic          reg_wr = 1'b0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_en  = '1;
  logic [N-1:0] exp_st  = '0;

  always #5 clk = ~clk;

  bus_grant_watchdog #(.N_MASTERS(N), .TIMEOUT(T), .REG_W(64)) u_dut (
    .clk(clk), .rst(rst), .req(req), .have_it(have_it), .gnt(gnt), .irq(irq),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [N-1:0] winner(input logic [N-1:0] r, input logic [N-1:0] e);
    logic [N-1:0] el = r & e;
    for (int i = 0; i < N; i++) if (el[i]) return N'(1) << i;
    return '0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic a, input logic [63:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [63:0] d);
    reg_addr = a; reg_wr = 1'b0;
    cyc(1);
    d = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [N-1:0] w, w2, r;
    void'($urandom(32'd4242));
    @(negedge clk); cyc(2);
    rst = 1'b0;
    cyc(1);
    // reset state
    check("R1 reset gnt", 64'(gnt), 0);
    check("R7 reset irq", 64'(irq), 0);
    rd(1'b0, d); check("R6 reset status", d, 0);
    rd(1'b1, d); check("R9 reset ctrl", d, 64'hFFFF);

    // R9 / R8: bit 0 and reserved bits ignored
    wr(1'b1, 64'hFFFF_FFFF_FFFF_0000);
    rd(1'b1, d); check("R9 bridge bit stays 1", d, 64'h0001);
    wr(1'b1, '1);
    rd(1'b1, d); check("R8 upper ctrl bits zero", d, 64'hFFFF);

    // R2: barred master never granted
    wr(1'b1, 64'h0);
    req = 16'h0080;
    cyc(6);
    check("R2 barred requester", 64'(gnt), 0);
    req = 16'h0081;
    cyc(1);
    check("R2 bridge still granted", 64'(gnt), 64'h1);
    req = '0; cyc(2);

    // random phase with acknowledge held high
    have_it = 1'b1;
    for (int it = 0; it < 60; it++) begin
      d = {$urandom, $urandom};
      wr(1'b1, d);
      exp_en = d[N-1:0] | N'(1);
      r = N'($urandom) & N'($urandom | $urandom);
      if (it % 5 == 0) r = N'(1) << ($urandom % N);
      req = r;
      cyc(1);
      w = winner(r, exp_en);
      check("R1 priority grant", 64'(gnt), 64'(w));
      if (w != '0) begin
        cyc(3);
        check("R3 grant held", 64'(gnt), 64'(w));
        req = r & ~w;
        cyc(1);
        check("R3 gap after release", 64'(gnt), 0);
        cyc(1);
        w2 = winner(r & ~w, exp_en);
        check("R3 next grant", 64'(gnt), 64'(w2));
      end
      req = '0; cyc(2);
    end
    check("R7 no broken in random phase", 64'(irq), 0);
    have_it = 1'b0;
    wr(1'b1, 64'hFFFF);
    rd(1'b1, d); check("R9 ctrl readback", d, 64'hFFFF);

    // R4: acknowledge on the last edge
    req = 16'h0008;
    cyc(1);
    check("R1 grant master 3", 64'(gnt), 64'h8);
    cyc(T - 1);
    have_it = 1'b1;
    cyc(3);
    have_it = 1'b0;
    cyc(2);
    check("R4 ack on last edge no flag", 64'(irq), 0);
    req = '0; cyc(2);
    rd(1'b0, d); check("R4 status after late ack", d, 0);

    // R5: acknowledge then drop
    have_it = 1'b1;
    req = 16'h0010;
    cyc(2);
    have_it = 1'b0;
    cyc(2 * T);
    check("R5 timer stopped", 64'(irq), 0);
    req = '0; cyc(2);
    rd(1'b0, d); check("R5 status clear", d, 0);

    // R4/R7: timeout for master 5
    req = 16'h0020;
    cyc(1);
    check("R1 grant master 5", 64'(gnt), 64'h20);
    cyc(T);
    check("R7 irq one cycle after flag", 64'(irq), 0);
    cyc(1);
    check("R7 irq after timeout", 64'(irq), 1);
    exp_st[5] = 1'b1;
    req = '0; cyc(2);
    rd(1'b0, d); check("R4 broken flag master 5", d, 64'(exp_st));

    // R6: writes to status ignored
    wr(1'b0, 64'h0);
    rd(1'b0, d); check("R6 status write ignored", d, 64'(exp_st));
    wr(1'b0, '1);
    rd(1'b0, d); check("R6 status write ones ignored", d, 64'(exp_st));
    check("R7 irq still high", 64'(irq), 1);

    // R4: second master times out while barred master requests
    wr(1'b1, 64'hFFFF & ~64'h0002);
    req = 16'h0402;
    cyc(1);
    check("R2 barred master skipped", 64'(gnt), 64'h400);
    cyc(T + 1);
    exp_st[10] = 1'b1;
    req = '0; cyc(2);
    rd(1'b0, d); check("R4 broken flag master 10", d, 64'(exp_st));

    // R6: reset clears
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
    exp_st = '0;
    check("R7 irq cleared by reset", 64'(irq), 0);
    rd(1'b0, d); check("R6 status cleared by reset", d, 0);
    rd(1'b1, d); check("R9 ctrl back to ones", d, 64'hFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule